// File: doc/BRIEF.md
# Wrapping Pin Span Mask Generator

This block converts the operand of a pin command into a 64-bit select mask. The operand names a base pin and a number of extra pins that follow it. The mask marks the base pin plus that many further pins. The pins form two groups of 32, and the selected run stays inside the group that holds the base pin. When the run passes the top pin of its group, it continues from that group's lowest pin. It never spills into the other group.

A prefix instruction can give a one-time replacement for the extra-pin count. The prefix is stored in a small holding register. The next instruction that issues clears it. If that instruction is a pin command, it also uses the stored count in place of the count in its operand. The mask comes out registered, one clock after the command. It comes with a strobe that marks it valid and a pulse that reports when the prefix was used.

Top module: `pin_span_mask`

## Requirements
- R1: While reset is held, and on the first clock after release, `sel_valid`, `pfx_used` and every bit of `sel_mask` are 0.
- R2: A cycle with `issue`=1 and `issue_pin`=1 produces `sel_valid`=1 and its mask on the next clock only. In every other cycle, `sel_valid` is 0 on the next clock.
- R3: Without a pending prefix, operand bits [5:0] are the base pin and bits [10:6] are the extra-pin count N. The mask then selects pin numbers base, base+1, ..., base+N (bit k of `sel_mask` is pin k).
- R4: Pin numbers wrap within the base pin's group of 32. Pins 0..31 form one group and pins 32..63 the other. Base 30 with N=3 gives pins 30, 31, 0, 1, and base 62 with N=3 gives pins 62, 63, 32, 33.
- R5: N=31 selects all 32 pins of the base pin's group and no pin of the other group.
- R6: A cycle with `pfx_wr`=1 stores `pfx_cnt` as a pending prefix. The next pin command replaces operand bits [10:6] with the stored count, and `pfx_used` pulses together with that command's mask.
- R7: A pending prefix is held through cycles with no issue. The next issue of any kind clears it. If that issue is not a pin command (`issue_pin`=0), the prefix is dropped unused: `pfx_used` stays 0, and a later pin command uses its own operand count.
- R8: An issue with `issue_pin`=0 produces no mask: `sel_mask` is all zero whenever `sel_valid` is 0.
- R9: A valid mask has exactly N+1 bits set, all in one group, where N is the count in effect.
- R10: When `pfx_wr` and a pin command arrive in the same cycle, the command sees the prefix state from before that cycle. The newly written prefix stays pending for the following instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pfx_wr | input | 1 | Prefix instruction issues this cycle |
| pfx_cnt | input | 5 | Extra-pin count carried by the prefix |
| issue | input | 1 | An instruction issues this cycle |
| issue_pin | input | 1 | The issuing instruction is a pin command |
| operand | input | 11 | Pin command operand: [10:6] extra count, [5:0] base pin |
| sel_valid | output | 1 | Mask on `sel_mask` is valid |
| sel_mask | output | 64 | Selected pins, one bit per pin |
| pfx_used | output | 1 | Pulse: a prefix count was applied to this mask |

## Verification
The assertions treat `issue_pin` as meaningful only when `issue` is high. The bench therefore never raises `issue_pin` without `issue`. The assertions also assume that reset holds long enough to clear both register stages. The bench keeps reset low for several clocks before it drives any command. Prefix writes may coincide with issues; the bench does this on purpose to test R10. A behavioural model in the bench lists the selected pins one by one with modular arithmetic. It compares its result with the outputs on every clock, across directed corner cases and a long random run.

// File: rtl/span_pkg.sv
package span_pkg;
  localparam int unsigned GRP_PINS   = 32;
  localparam int unsigned GRP_COUNT  = 2;
  localparam int unsigned CNT_BITS   = $clog2(GRP_PINS);
  localparam int unsigned GSEL_BITS  = $clog2(GRP_COUNT);
  localparam int unsigned BASE_BITS  = CNT_BITS + GSEL_BITS;
  localparam int unsigned OPND_BITS  = BASE_BITS + CNT_BITS;

  typedef struct packed {
    logic                valid;
    logic [CNT_BITS-1:0] cnt;
  } pfx_state_t;
endpackage

// File: rtl/span_prefix_hold.sv
module span_prefix_hold #(
  parameter int unsigned CW = span_pkg::CNT_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pfx_wr,
  input  logic [CW-1:0] pfx_cnt,
  input  logic          issue,
  output logic          pend_valid,
  output logic [CW-1:0] pend_cnt
);
  logic          valid_q;
  logic [CW-1:0] cnt_q;

  // Prefix write wins; otherwise any issue consumes the pending prefix.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cnt_q   <= '0;
    end else if (pfx_wr) begin
      valid_q <= 1'b1;
      cnt_q   <= pfx_cnt;
    end else if (issue) begin
      valid_q <= 1'b0;
    end
  end

  assign pend_valid = valid_q;
  assign pend_cnt   = cnt_q;

  a_r6_prefix_captured: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_wr |=> (pend_valid && pend_cnt == $past(pfx_cnt)));

  a_r7_prefix_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !pfx_wr) |=> !pend_valid);

  a_r7_prefix_held_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue && !pfx_wr) |=> $stable(pend_valid));
endmodule

// File: rtl/span_mask_calc.sv
module span_mask_calc #(
  parameter int unsigned GW = span_pkg::GRP_PINS,
  parameter int unsigned NG = span_pkg::GRP_COUNT,
  localparam int unsigned CW  = $clog2(GW),
  localparam int unsigned SW  = $clog2(NG),
  localparam int unsigned BW  = CW + SW,
  localparam int unsigned MW  = GW * NG
) (
  input  logic [BW-1:0] base,
  input  logic [CW-1:0] cnt,
  output logic [MW-1:0] mask
);
  localparam logic [CW-1:0] TOP_IDX = CW'(GW - 1);

  logic [CW-1:0]   start;
  logic [SW-1:0]   grp;
  logic [GW-1:0]   run;
  logic [2*GW-1:0] dbl;
  logic [GW-1:0]   rot;

  assign start = base[CW-1:0];
  assign grp   = base[BW-1:CW];

  // cnt+1 low ones, then rotate left by start inside one group.
  always_comb begin
    run = {GW{1'b1}} >> (TOP_IDX - cnt);
    dbl = {run, run} << start;
    rot = dbl[2*GW-1:GW];
  end

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign mask[g*GW +: GW] = (grp == SW'(g)) ? rot : '0;
  end
endmodule

// File: rtl/span_out_stage.sv
module span_out_stage #(
  parameter int unsigned GW = span_pkg::GRP_PINS,
  parameter int unsigned NG = span_pkg::GRP_COUNT,
  localparam int unsigned CW = $clog2(GW),
  localparam int unsigned MW = GW * NG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          used_in,
  input  logic [CW-1:0] cnt_in,
  input  logic [MW-1:0] mask_in,
  output logic          sel_valid,
  output logic          pfx_used,
  output logic [MW-1:0] sel_mask
);
  logic          valid_q;
  logic          used_q;
  logic [CW-1:0] cnt_q;
  logic [MW-1:0] mask_q;
  logic [NG-1:0] grp_nz;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      used_q  <= 1'b0;
      cnt_q   <= '0;
      mask_q  <= '0;
    end else begin
      valid_q <= fire;
      used_q  <= fire & used_in;
      cnt_q   <= fire ? cnt_in : '0;
      mask_q  <= fire ? mask_in : '0;
    end
  end

  for (genvar g = 0; g < NG; g++) begin : g_nz
    assign grp_nz[g] = |mask_q[g*GW +: GW];
  end

  assign sel_valid = valid_q;
  assign pfx_used  = used_q;
  assign sel_mask  = mask_q;

  a_r2_valid_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> sel_valid);

  a_r2_quiet_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !sel_valid);

  a_r8_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> (sel_mask == '0));

  a_r4_single_group: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> ($countones(grp_nz) == 1));

  a_r9_span_size: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> ($countones(sel_mask) == int'(cnt_q) + 1));

  a_r6_used_with_mask: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_used |-> sel_valid);
endmodule

// File: rtl/pin_span_mask.sv
module pin_span_mask #(
  parameter int unsigned GW = span_pkg::GRP_PINS,
  parameter int unsigned NG = span_pkg::GRP_COUNT,
  localparam int unsigned CW = $clog2(GW),
  localparam int unsigned SW = $clog2(NG),
  localparam int unsigned BW = CW + SW,
  localparam int unsigned OW = BW + CW,
  localparam int unsigned MW = GW * NG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pfx_wr,
  input  logic [CW-1:0] pfx_cnt,
  input  logic          issue,
  input  logic          issue_pin,
  input  logic [OW-1:0] operand,
  output logic          sel_valid,
  output logic [MW-1:0] sel_mask,
  output logic          pfx_used
);
  logic          pend_valid;
  logic [CW-1:0] pend_cnt;
  logic          fire;
  logic          take_pfx;
  logic [CW-1:0] eff_cnt;
  logic [BW-1:0] base;
  logic [MW-1:0] raw_mask;

  span_prefix_hold #(.CW(CW)) u_pfx (
    .clk       (clk),
    .rst_n     (rst_n),
    .pfx_wr    (pfx_wr),
    .pfx_cnt   (pfx_cnt),
    .issue     (issue),
    .pend_valid(pend_valid),
    .pend_cnt  (pend_cnt)
  );

  assign fire     = issue & issue_pin;
  assign take_pfx = fire & pend_valid;
  assign eff_cnt  = take_pfx ? pend_cnt : operand[OW-1:BW];
  assign base     = operand[BW-1:0];

  span_mask_calc #(.GW(GW), .NG(NG)) u_calc (
    .base(base),
    .cnt (eff_cnt),
    .mask(raw_mask)
  );

  span_out_stage #(.GW(GW), .NG(NG)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .used_in  (take_pfx),
    .cnt_in   (eff_cnt),
    .mask_in  (raw_mask),
    .sel_valid(sel_valid),
    .pfx_used (pfx_used),
    .sel_mask (sel_mask)
  );

  a_r10_used_means_pending: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_used |-> $past(pend_valid));

  a_r3_base_pin_selected: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> sel_mask[$past(base)]);
endmodule

// File: tb/pin_span_mask_tb.sv
module pin_span_mask_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pfx_wr = 1'b0;
  logic [4:0]  pfx_cnt = '0;
  logic        issue = 1'b0;
  logic        issue_pin = 1'b0;
  logic [10:0] operand = '0;
  logic        sel_valid;
  logic [63:0] sel_mask;
  logic        pfx_used;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  bit          m_pv = 1'b0;
  int          m_pc = 0;
  bit          e_valid;
  bit          e_used;
  logic [63:0] e_mask;

  always #2.5 clk = ~clk;

  pin_span_mask u_dut (
    .clk(clk), .rst_n(rst_n), .pfx_wr(pfx_wr), .pfx_cnt(pfx_cnt),
    .issue(issue), .issue_pin(issue_pin), .operand(operand),
    .sel_valid(sel_valid), .sel_mask(sel_mask), .pfx_used(pfx_used)
  );

  always @(posedge clk) cycles++;

  function automatic logic [63:0] ref_mask(int base, int n);
    logic [63:0] m = '0;
    int grp = base / 32;
    int pos = base % 32;
    for (int i = 0; i <= n; i++) m[grp * 32 + ((pos + i) % 32)] = 1'b1;
    return m;
  endfunction

  task automatic check(string req);
    tests++;
    if (sel_valid !== e_valid || sel_mask !== e_mask || pfx_used !== e_used) begin
      fails++;
      $display("FAIL %s: got v=%0b m=%h u=%0b, expected v=%0b m=%h u=%0b",
               req, sel_valid, sel_mask, pfx_used, e_valid, e_mask, e_used);
    end
  endtask

  // One instruction slot: drive, predict, step to after the edge, compare.
  task automatic slot(string req, bit pw, int pv, bit is, bit ip, int base, int n);
    int cnt;
    pfx_wr = pw; pfx_cnt = 5'(pv); issue = is; issue_pin = ip;
    operand = {5'(n), 6'(base)};
    e_valid = is && ip;
    e_used  = is && ip && m_pv;
    cnt     = e_used ? m_pc : n;
    e_mask  = e_valid ? ref_mask(base, cnt) : '0;
    if (pw) begin m_pv = 1'b1; m_pc = pv; end
    else if (is) m_pv = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(req);
  endtask

  task automatic lit_check(string req, logic [63:0] want);
    tests++;
    if (sel_mask !== want) begin
      fails++;
      $display("FAIL %s: got m=%h, expected m=%h", req, sel_mask, want);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    e_valid = 0; e_used = 0; e_mask = '0;
    check("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");

    slot("R3 base5 n0", 0, 0, 1, 1, 5, 0);
    slot("R3 base10 n4", 0, 0, 1, 1, 10, 4);
    slot("R3 base40 n2", 0, 0, 1, 1, 40, 2);
    slot("R2 idle", 0, 0, 0, 0, 0, 0);
    slot("R4 base30 n3", 0, 0, 1, 1, 30, 3);
    lit_check("R4 literal low wrap", 64'h0000_0000_C000_0003);
    slot("R4 base62 n3", 0, 0, 1, 1, 62, 3);
    lit_check("R4 literal high wrap", 64'hC000_0003_0000_0000);
    slot("R5 base0 n31", 0, 0, 1, 1, 0, 31);
    slot("R5 base45 n31", 0, 0, 1, 1, 45, 31);
    lit_check("R5 literal full high", 64'hFFFF_FFFF_0000_0000);
    slot("R8 non-pin issue", 0, 0, 1, 0, 7, 6);

    slot("R6 prefix write", 1, 3, 0, 0, 0, 0);
    slot("R6 prefix applied", 0, 0, 1, 1, 30, 0);
    lit_check("R6 literal", 64'h0000_0000_C000_0003);
    slot("R6 after use", 0, 0, 1, 1, 30, 0);

    slot("R7 prefix write", 1, 9, 0, 0, 0, 0);
    slot("R7 idle hold", 0, 0, 0, 0, 0, 0);
    slot("R7 idle hold", 0, 0, 0, 0, 0, 0);
    slot("R7 held then used", 0, 0, 1, 1, 33, 1);
    slot("R7 prefix write", 1, 20, 0, 0, 0, 0);
    slot("R7 non-pin consumes", 0, 0, 1, 0, 0, 0);
    slot("R7 own count", 0, 0, 1, 1, 12, 1);

    slot("R10 write+cmd no prior", 1, 5, 1, 1, 3, 2);
    slot("R10 new prefix pending", 0, 0, 1, 1, 3, 0);
    slot("R10 prefix write", 1, 7, 0, 0, 0, 0);
    slot("R10 write+cmd with prior", 1, 2, 1, 1, 60, 0);
    slot("R10 second prefix", 0, 0, 1, 1, 60, 0);

    for (int k = 0; k < 400; k++) begin
      bit is = ($urandom % 3) != 0;
      bit ip = is && ($urandom % 4 != 0);
      slot("R9 random", ($urandom % 4) == 0, $urandom % 32, is, ip,
           $urandom % 64, $urandom % 32);
    end
    slot("R2 drain", 0, 0, 0, 0, 0, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got cycles=%0d, expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule